// File: doc/BRIEF.md
# Override-Muxed General-Purpose I/O Port

This block is one general-purpose I/O port with a parameterised number of pins (eight by default). Software owns three storage bits per pin: a pull-up enable, a direction bit and an output value. It reads the pin levels back through a synchronizer. Writes and reads use shared per-register strobes on a simple register bus. The read data bus returns the OR of every register whose read strobe is high.

Alternate-function peripherals sit beside the port. Through a set of per-pin enable/value pairs they can take over the pull-up, the output driver enable, the driven value and the digital input enable. They can also flip the stored output bit. The pad side gets the resolved drive value, output enable and pull-up enable. Peripherals get the gated pad input straight from the gate, with no synchronizer delay. During sleep the digital input is gated off unless a peripheral overrides the input enable.

Top module: `gpio_ovr_port`

## Requirements
- R1: `pad_pu_o[n]` equals `pu_ovr_val_i[n]` when `pu_ovr_en_i[n]` is 1. Otherwise it equals the stored pull-up bit n.
- R2: `pad_oe_o[n]` equals `dir_ovr_val_i[n]` when `dir_ovr_en_i[n]` is 1. Otherwise it equals the stored direction bit n.
- R3: When `pad_oe_o[n]` is 1, `pad_out_o[n]` is `val_ovr_val_i[n]` if `val_ovr_en_i[n]` is 1 and the stored output bit otherwise. When `pad_oe_o[n]` is 0, `pad_out_o[n]` is 0.
- R4: Each clock edge with `tgl_ovr_i[n]` high inverts stored output bit n. This inversion is applied after any port-register write in the same cycle.
- R5: The input enable of pin n is `ie_ovr_val_i[n]` when `ie_ovr_en_i[n]` is 1 and `!sleep_i` otherwise. A disabled input presents 0 to both `din_o` and the synchronizer.
- R6: The PIN readback of pin n is its gated input as sampled two clock edges earlier.
- R7: `din_o` is the gated pad input, combinational with no register stage.
- R8: A PIN write toggles the stored output bits where `wdata_i` is 1 and leaves the bits where it is 0 unchanged. Writing 0x00 therefore changes nothing.
- R9: While `rst_ni` is low, the pull-up, direction and output bits are held at 0, and the synchronizer is cleared too.
- R10: `rdata_o` is the OR of the stored pull-up bits (when `pue_re_i` is high), direction bits (`ddr_re_i`), output bits (`port_re_i`) and synchronized pin levels (`pin_re_i`). Override values never appear on it. With no read strobe high it is 0.
- R11: A pull-up, direction or port write stores `wdata_i` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I/O clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Sleep state; disables digital inputs by default |
| pue_we_i | input | 1 | Pull-up register write strobe |
| ddr_we_i | input | 1 | Direction register write strobe |
| port_we_i | input | 1 | Output register write strobe |
| pin_we_i | input | 1 | PIN write strobe (toggle mask) |
| wdata_i | input | N | Write data |
| pue_re_i | input | 1 | Pull-up register read strobe |
| ddr_re_i | input | 1 | Direction register read strobe |
| port_re_i | input | 1 | Output register read strobe |
| pin_re_i | input | 1 | Synchronized pin read strobe |
| rdata_o | output | N | Read data |
| pu_ovr_en_i | input | N | Pull-up override enable per pin |
| pu_ovr_val_i | input | N | Pull-up override value per pin |
| dir_ovr_en_i | input | N | Direction override enable per pin |
| dir_ovr_val_i | input | N | Direction override value per pin |
| val_ovr_en_i | input | N | Drive value override enable per pin |
| val_ovr_val_i | input | N | Drive value override value per pin |
| tgl_ovr_i | input | N | Toggle override per pin |
| ie_ovr_en_i | input | N | Input enable override enable per pin |
| ie_ovr_val_i | input | N | Input enable override value per pin |
| pad_in_i | input | N | Raw pad input |
| pad_out_o | output | N | Pad drive value |
| pad_oe_o | output | N | Pad output driver enable |
| pad_pu_o | output | N | Pad pull-up enable |
| din_o | output | N | Unsynchronized gated input for peripherals |

## Verification
The bench goes after the following corner cases:

- **Toggles that collide with writes.** A port write with a toggle override on the same edge must store the inverted written value. A design that ignored the toggle, or applied it before the write, would read back the plain written value.
- **Zero PIN write.** A PIN write of 0x00 must leave the output register alone. A design that stored the write data would clear the register.
- **Readback delay.** The bench checks that PIN readback lags the pad by exactly two edges. Off-by-one pipelines show up at each pad change.
- **Sleep gating and override precedence.** Sleep with and without the input-enable override is checked on both `din_o` and the readback. A design that synchronized `din_o`, or let sleep win over the override, would present stale or zeroed levels.
- **Drive gating.** Random stimulus checks that drive value overrides are masked while the driver is off.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  typedef struct packed {
    logic pu_en;
    logic pu_val;
    logic dir_en;
    logic dir_val;
    logic val_en;
    logic val_val;
    logic ie_en;
    logic ie_val;
  } pin_ovr_t;
endpackage

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pue_we_i,
  input  logic         ddr_we_i,
  input  logic         port_we_i,
  input  logic         pin_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] tgl_i,
  output logic [W-1:0] pue_o,
  output logic [W-1:0] ddr_o,
  output logic [W-1:0] port_o
);
  logic [W-1:0] pue_q, ddr_q, port_q, port_nxt, flip;

  // port write first, then PIN-write mask and toggle override invert it
  always_comb begin
    flip     = (pin_we_i ? wdata_i : '0) ^ tgl_i;
    port_nxt = (port_we_i ? wdata_i : port_q) ^ flip;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pue_q  <= '0;
      ddr_q  <= '0;
      port_q <= '0;
    end else begin
      if (pue_we_i) pue_q <= wdata_i;
      if (ddr_we_i) ddr_q <= wdata_i;
      port_q <= port_nxt;
    end
  end

  assign pue_o  = pue_q;
  assign ddr_o  = ddr_q;
  assign port_o = port_q;

  p_reset_clr_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (pue_q == '0 && ddr_q == '0 && port_q == '0));

  p_pin_wr0_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_we_i && wdata_i == '0 && !port_we_i && tgl_i == '0) |=> $stable(port_q));

  p_tgl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!port_we_i && !pin_we_i) |=> port_q == ($past(port_q) ^ $past(tgl_i)));
endmodule

// File: rtl/gpio_ovr_pin.sv
module gpio_ovr_pin
  import gpio_ovr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sleep_i,
  input  logic     pue_i,
  input  logic     ddr_i,
  input  logic     port_i,
  input  pin_ovr_t ovr_i,
  input  logic     pad_in_i,
  output logic     pu_o,
  output logic     oe_o,
  output logic     out_o,
  output logic     din_o
);
  logic ie, val;

  always_comb begin
    pu_o  = ovr_i.pu_en  ? ovr_i.pu_val  : pue_i;
    oe_o  = ovr_i.dir_en ? ovr_i.dir_val : ddr_i;
    val   = ovr_i.val_en ? ovr_i.val_val : port_i;
    out_o = oe_o & val;
    ie    = ovr_i.ie_en  ? ovr_i.ie_val  : ~sleep_i;
    din_o = pad_in_i & ie;
  end

  p_drv_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> !out_o);

  p_sleep_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && !ovr_i.ie_en) |-> !din_o);
endmodule

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

  p_sync_lat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(rst_ni, 2)) |-> q_o == $past(d_i, 2));
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sleep_i,
  input  logic         pue_we_i,
  input  logic         ddr_we_i,
  input  logic         port_we_i,
  input  logic         pin_we_i,
  input  logic [N-1:0] wdata_i,
  input  logic         pue_re_i,
  input  logic         ddr_re_i,
  input  logic         port_re_i,
  input  logic         pin_re_i,
  output logic [N-1:0] rdata_o,
  input  logic [N-1:0] pu_ovr_en_i,
  input  logic [N-1:0] pu_ovr_val_i,
  input  logic [N-1:0] dir_ovr_en_i,
  input  logic [N-1:0] dir_ovr_val_i,
  input  logic [N-1:0] val_ovr_en_i,
  input  logic [N-1:0] val_ovr_val_i,
  input  logic [N-1:0] tgl_ovr_i,
  input  logic [N-1:0] ie_ovr_en_i,
  input  logic [N-1:0] ie_ovr_val_i,
  input  logic [N-1:0] pad_in_i,
  output logic [N-1:0] pad_out_o,
  output logic [N-1:0] pad_oe_o,
  output logic [N-1:0] pad_pu_o,
  output logic [N-1:0] din_o
);
  localparam int MSB = N - 1;

  logic [MSB:0] pue, ddr, port, pin_sync;

  gpio_ovr_regs #(.W(N)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pue_we_i  (pue_we_i),
    .ddr_we_i  (ddr_we_i),
    .port_we_i (port_we_i),
    .pin_we_i  (pin_we_i),
    .wdata_i   (wdata_i),
    .tgl_i     (tgl_ovr_i),
    .pue_o     (pue),
    .ddr_o     (ddr),
    .port_o    (port)
  );

  for (genvar i = 0; i < N; i++) begin : g_pin
    pin_ovr_t ovr;
    assign ovr = '{pu_en:   pu_ovr_en_i[i],  pu_val:  pu_ovr_val_i[i],
                   dir_en:  dir_ovr_en_i[i], dir_val: dir_ovr_val_i[i],
                   val_en:  val_ovr_en_i[i], val_val: val_ovr_val_i[i],
                   ie_en:   ie_ovr_en_i[i],  ie_val:  ie_ovr_val_i[i]};

    gpio_ovr_pin u_pin (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sleep_i  (sleep_i),
      .pue_i    (pue[i]),
      .ddr_i    (ddr[i]),
      .port_i   (port[i]),
      .ovr_i    (ovr),
      .pad_in_i (pad_in_i[i]),
      .pu_o     (pad_pu_o[i]),
      .oe_o     (pad_oe_o[i]),
      .out_o    (pad_out_o[i]),
      .din_o    (din_o[i])
    );
  end

  gpio_ovr_sync #(.W(N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (din_o),
    .q_o    (pin_sync)
  );

  always_comb begin
    rdata_o = '0;
    if (pue_re_i)  rdata_o |= pue;
    if (ddr_re_i)  rdata_o |= ddr;
    if (port_re_i) rdata_o |= port;
    if (pin_re_i)  rdata_o |= pin_sync;
  end

  p_rd_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pue_re_i && !ddr_re_i && !port_re_i && !pin_re_i) |-> rdata_o == '0);
endmodule

// File: tb/tb_gpio_ovr_port.sv
`timescale 1ns/1ps
module tb_gpio_ovr_port;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sleep_i = 1'b0;
  logic pue_we_i = 1'b0, ddr_we_i = 1'b0, port_we_i = 1'b0, pin_we_i = 1'b0;
  logic pue_re_i = 1'b0, ddr_re_i = 1'b0, port_re_i = 1'b0, pin_re_i = 1'b0;
  logic [N-1:0] wdata_i = '0;
  logic [N-1:0] pu_en = '0, pu_val = '0, dir_en = '0, dir_val = '0;
  logic [N-1:0] val_en = '0, val_val = '0, tgl = '0, ie_en = '0, ie_val = '0;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] rdata_o, pad_out_o, pad_oe_o, pad_pu_o, din_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_tag = "R10";

  logic [N-1:0] m_pue = '0, m_ddr = '0, m_port = '0, m_s1 = '0, m_s2 = '0;

  always #2 clk = ~clk;

  gpio_ovr_port #(.N(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_i(sleep_i),
    .pue_we_i(pue_we_i), .ddr_we_i(ddr_we_i), .port_we_i(port_we_i), .pin_we_i(pin_we_i),
    .wdata_i(wdata_i),
    .pue_re_i(pue_re_i), .ddr_re_i(ddr_re_i), .port_re_i(port_re_i), .pin_re_i(pin_re_i),
    .rdata_o(rdata_o),
    .pu_ovr_en_i(pu_en), .pu_ovr_val_i(pu_val), .dir_ovr_en_i(dir_en), .dir_ovr_val_i(dir_val),
    .val_ovr_en_i(val_en), .val_ovr_val_i(val_val), .tgl_ovr_i(tgl),
    .ie_ovr_en_i(ie_en), .ie_ovr_val_i(ie_val),
    .pad_in_i(pad_in), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o), .pad_pu_o(pad_pu_o),
    .din_o(din_o)
  );

  function automatic logic [N-1:0] sel(input logic [N-1:0] en, input logic [N-1:0] v,
                                       input logic [N-1:0] dflt);
    return (en & v) | (~en & dflt);
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: check outputs mid-cycle, then advance the model across the edge
  task automatic cycle();
    logic [N-1:0] ie, g, oe, rd, nport;
    @(negedge clk);
    #1;
    ie = sel(ie_en, ie_val, {N{~sleep_i}});
    g  = pad_in & ie;
    oe = sel(dir_en, dir_val, m_ddr);
    rd = (pue_re_i ? m_pue : '0) | (ddr_re_i ? m_ddr : '0) |
         (port_re_i ? m_port : '0) | (pin_re_i ? m_s2 : '0);
    chk("R1 pull-up", pad_pu_o, sel(pu_en, pu_val, m_pue));
    chk("R2 output enable", pad_oe_o, oe);
    chk("R3 drive value", pad_out_o, oe & sel(val_en, val_val, m_port));
    chk("R7 peripheral input", din_o, g);
    chk({cur_tag, " read data"}, rdata_o, rd);
    if (!rst_ni) begin
      m_pue = '0; m_ddr = '0; m_port = '0; m_s1 = '0; m_s2 = '0;
    end else begin
      nport = (port_we_i ? wdata_i : m_port) ^ (pin_we_i ? wdata_i : '0) ^ tgl;
      if (pue_we_i) m_pue = wdata_i;
      if (ddr_we_i) m_ddr = wdata_i;
      m_port = nport;
      m_s2 = m_s1;
      m_s1 = g;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    {pue_we_i, ddr_we_i, port_we_i, pin_we_i} = '0;
    {pue_re_i, ddr_re_i, port_re_i, pin_re_i} = '0;
    wdata_i = '0; tgl = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R9: writes during reset are ignored, everything reads 0
    cur_tag = "R9";
    for (int k = 0; k < 3; k++) begin
      pue_we_i = 1; ddr_we_i = 1; port_we_i = 1; wdata_i = 8'hFF; tgl = 8'h0F;
      pue_re_i = 1; ddr_re_i = 1; port_re_i = 1; pin_re_i = 1; pad_in = 8'hFF;
      cycle();
    end
    idle(); pad_in = '0;
    rst_ni = 1'b1;
    // R11: plain writes
    cur_tag = "R11";
    pue_we_i = 1; ddr_we_i = 1; port_we_i = 1; wdata_i = 8'hA5; cycle();
    idle(); ddr_we_i = 1; wdata_i = 8'h3C; cycle();
    idle(); port_we_i = 1; wdata_i = 8'hF0; cycle();
    idle(); pue_re_i = 1; cycle();
    idle(); ddr_re_i = 1; cycle();
    idle(); port_re_i = 1; cycle();
    // R4: toggle override alone, then together with a port write
    cur_tag = "R4";
    idle(); tgl = 8'h0F; cycle();
    idle(); port_re_i = 1; cycle();
    idle(); port_we_i = 1; wdata_i = 8'h00; tgl = 8'h01; cycle();
    idle(); port_re_i = 1; cycle();
    // R8: PIN write 0 has no effect, 1s toggle
    cur_tag = "R8";
    idle(); pin_we_i = 1; wdata_i = 8'h00; cycle();
    idle(); port_re_i = 1; cycle();
    idle(); pin_we_i = 1; wdata_i = 8'h81; cycle();
    idle(); port_re_i = 1; cycle();
    // R6: two-edge readback delay
    cur_tag = "R6";
    idle(); pin_re_i = 1; pad_in = 8'h5A;
    for (int k = 0; k < 3; k++) cycle();
    pad_in = 8'hA5;
    for (int k = 0; k < 3; k++) cycle();
    // R5: sleep gating and input-enable override
    cur_tag = "R5";
    sleep_i = 1; pad_in = 8'hFF;
    for (int k = 0; k < 3; k++) cycle();
    ie_en = 8'h0F; ie_val = 8'h0F;
    for (int k = 0; k < 3; k++) cycle();
    ie_en = 8'hF0; ie_val = 8'h30; sleep_i = 0;
    for (int k = 0; k < 3; k++) cycle();
    // random mix
    cur_tag = "R10";
    for (int k = 0; k < 3000; k++) begin
      sleep_i   = $urandom_range(0, 3) == 0;
      pue_we_i  = $urandom_range(0, 3) == 0;
      ddr_we_i  = $urandom_range(0, 3) == 0;
      port_we_i = $urandom_range(0, 3) == 0;
      pin_we_i  = $urandom_range(0, 3) == 0;
      pue_re_i  = $urandom_range(0, 1) == 0;
      ddr_re_i  = $urandom_range(0, 2) == 0;
      port_re_i = $urandom_range(0, 2) == 0;
      pin_re_i  = $urandom_range(0, 1) == 0;
      wdata_i = N'($urandom); pad_in = N'($urandom);
      pu_en = N'($urandom); pu_val = N'($urandom);
      dir_en = N'($urandom); dir_val = N'($urandom);
      val_en = N'($urandom); val_val = N'($urandom);
      ie_en = N'($urandom); ie_val = N'($urandom);
      tgl = N'($urandom) & N'($urandom);
      cycle();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule